// File: doc/BRIEF.md
# Guarded Delayed-Write Gatekeeper

This block stands between a processor bus and a protected memory and is accessed like a memory location. When the processor selects it and writes, the block takes the address and data into holding registers and pulses a capture strobe. It then waits through a guard window of a configurable number of cycles before it drives a low-active write strobe toward the protected memory. The processor's wait-state logic stalls on a one-cycle acknowledge that the block raises at the end of the access.

An upset monitor elsewhere on the chip drives a low-active inhibit input. If inhibit is seen low on any cycle of the guard window, the write is cancelled and never reaches memory. The bus still receives its acknowledge so that it does not hang, and a sticky flag records that a write was dropped. Reset clears every piece of state and also cancels any write in flight.

Top module: `gk_write_guard`

## Requirements
- R1: A transaction starts on a rising clock edge where the machine is idle, `sel_n` is 0 and `bus_wr` is 1. With `sel_n` at 1, or with `bus_wr` at 0, no transaction starts and `cap_n` stays high.
- R2: At the accepting edge, `bus_addr` and `bus_wdata` are loaded into the holding registers, and `cap_n` is low for exactly the one cycle that follows that edge.
- R3: `mem_we_n` falls exactly `DLY_CYC`+1 cycles after `cap_n` falls. With the default of 3 at 100 MHz, this is 40 ns, which meets the 30 ns minimum guard time.
- R4: Once it falls, `mem_we_n` stays low for exactly `WR_CYC` consecutive cycles.
- R5: `ack` is high for exactly one cycle, which is the cycle right after the last strobe cycle. The block is idle again on the cycle after that.
- R6: The guard window is made up of the `DLY_CYC` edges that follow the capture cycle. If `inhibit_n` is 0 at any of these edges, the write is aborted. `mem_we_n` stays high, `ack` is high for the single cycle after that edge, and the block is idle one cycle later.
- R7: `abort_flag` goes to 1 in the same cycle as the abort acknowledge. It then stays at 1 through any later transactions, until reset.
- R8: `inhibit_n` has no effect outside the guard window. This includes the capture cycle, the strobe cycles and idle time.
- R9: Selects that arrive while a transaction is in progress are ignored, including at the edge that ends the ack or abort cycle. If `sel_n` is held low with `bus_wr` high, a new transaction starts every `DLY_CYC`+`WR_CYC`+3 cycles.
- R10: `mem_addr` and `mem_wdata` show the last captured values and change only at an accepting edge.
- R11: `rst_n` is low-active and asynchronous. While it is low, the block is idle, `mem_we_n` and `cap_n` are 1, `ack` and `abort_flag` are 0, and the holding registers are 0. A transaction in flight when reset arrives never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, low-active |
| sel_n | input | 1 | Block select, low-active |
| bus_wr | input | 1 | Bus write qualifier |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | DW | Bus write data |
| inhibit_n | input | 1 | Upset inhibit, low-active |
| cap_n | output | 1 | Capture strobe, low-active |
| mem_we_n | output | 1 | Delayed write strobe to protected memory, low-active |
| mem_addr | output | AW | Captured address |
| mem_wdata | output | DW | Captured data |
| ack | output | 1 | Access acknowledge for wait-state logic |
| abort_flag | output | 1 | Sticky record of an aborted write |

## Verification
The bench builds the block with `DLY_CYC`=3 and `WR_CYC`=2, using a 12-bit address and 16-bit data. With these values, inhibit can be pulsed once at each of the three guard edges, and once just before and once just after the window. A back-to-back held select covers two complete 8-cycle transactions in a short run. The narrow buses keep the distinct capture patterns readable, while the full capture, delay, strobe, acknowledge and abort sequence is still exercised. Reset is driven in the middle of a guard window to show that the strobe is cancelled.

// File: rtl/gk_pkg.sv
package gk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_DELAY,
        ST_WRITE,
        ST_ACK,
        ST_ABORT
    } gk_state_e;

    typedef struct packed {
        gk_state_e st;
        logic      aborted;
    } gk_ctrl_t;

endpackage

// File: rtl/gk_tick_counter.sv
module gk_tick_counter #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // The count never moves unless it is loaded or decremented.
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$past(dec)) |-> $stable(cnt_q)); // R3

endmodule

// File: rtl/gk_hold_reg.sv
module gk_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = load ? d : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(q)); // R10

endmodule

// File: rtl/gk_write_guard.sv
module gk_write_guard
    import gk_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int DLY_CYC = 3,
    parameter int WR_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          inhibit_n,
    output logic          cap_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          ack,
    output logic          abort_flag
);

    localparam int MAXC = (DLY_CYC > WR_CYC) ? DLY_CYC : WR_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] DLY_LOAD = CW'(DLY_CYC - 1);
    localparam logic [CW-1:0] WR_LOAD  = CW'(WR_CYC - 1);

    gk_ctrl_t      ctrl_d, ctrl_q;
    logic          cnt_load;
    logic [CW-1:0] cnt_load_val;
    logic          cnt_dec;
    logic          cnt_zero;
    logic          cap_en;

    always_comb begin
        ctrl_d       = ctrl_q;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        cap_en       = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (!sel_n && bus_wr) begin
                    ctrl_d.st = ST_CAPTURE;
                    cap_en    = 1'b1;
                end
            end
            ST_CAPTURE: begin
                ctrl_d.st    = ST_DELAY;
                cnt_load     = 1'b1;
                cnt_load_val = DLY_LOAD;
            end
            ST_DELAY: begin
                if (!inhibit_n) begin
                    ctrl_d.st      = ST_ABORT;
                    ctrl_d.aborted = 1'b1;
                end else if (cnt_zero) begin
                    ctrl_d.st    = ST_WRITE;
                    cnt_load     = 1'b1;
                    cnt_load_val = WR_LOAD;
                end
            end
            ST_WRITE: begin
                if (cnt_zero) begin
                    ctrl_d.st = ST_ACK;
                end
            end
            ST_ACK, ST_ABORT: begin
                ctrl_d.st = ST_IDLE;
            end
            default: begin
                ctrl_d.st = ST_IDLE;
            end
        endcase
        cnt_dec = !cnt_load && ((ctrl_q.st == ST_DELAY) || (ctrl_q.st == ST_WRITE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, aborted: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    gk_tick_counter #(.CW(CW)) u_guard_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    gk_hold_reg #(.W(AW)) u_addr_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_en),
        .d     (bus_addr),
        .q     (mem_addr)
    );

    gk_hold_reg #(.W(DW)) u_data_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_en),
        .d     (bus_wdata),
        .q     (mem_wdata)
    );

    assign cap_n      = (ctrl_q.st != ST_CAPTURE);
    assign mem_we_n   = (ctrl_q.st != ST_WRITE);
    assign ack        = (ctrl_q.st == ST_ACK) || (ctrl_q.st == ST_ABORT);
    assign abort_flag = ctrl_q.aborted;

    // ---------------- checks ----------------
    localparam int SW = $clog2(DLY_CYC + 3);
    logic [SW-1:0] since_cap_d, since_cap_q;

    always_comb begin
        since_cap_d = since_cap_q;
        if (!cap_n) begin
            since_cap_d = SW'(1);
        end else if ((since_cap_q != '0) && (since_cap_q != SW'(DLY_CYC + 2))) begin
            since_cap_d = since_cap_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_cap_q <= '0;
        end else begin
            since_cap_q <= since_cap_d;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (mem_we_n && cap_n && !ack); // R11
        end
    end

    AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_n |=> cap_n); // R2

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (since_cap_q == SW'(DLY_CYC + 1))); // R3

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R5

    AST_STROBE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(inhibit_n)); // R6

    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag |=> abort_flag); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> ($stable(mem_addr) && $stable(mem_wdata))); // R10

endmodule

// File: tb/gk_write_guard_tb.sv
`timescale 1ns/100ps
module gk_write_guard_tb;

    localparam int AW  = 12;
    localparam int DW  = 16;
    localparam int DLY = 3;
    localparam int WID = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          inhibit_n = 1'b1;
    logic          cap_n, mem_we_n, ack, abort_flag;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gk_write_guard #(.AW(AW), .DW(DW), .DLY_CYC(DLY), .WR_CYC(WID)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .inhibit_n(inhibit_n),
        .cap_n(cap_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .ack(ack), .abort_flag(abort_flag)
    );

    // ---------- behavioural reference: transaction timeline ----------
    bit            m_busy = 0;
    bit            m_sticky = 0;
    int            e_cnt = 0;
    int            t0 = 0;
    int            ab_edge = -1;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_sticky = 0; ab_edge = -1; m_addr = '0; m_data = '0;
        end else begin
            bit was;
            int r;
            e_cnt = e_cnt + 1;
            was = m_busy;
            if (m_busy) begin
                r = e_cnt - t0;
                if (ab_edge >= 0) begin
                    if (e_cnt > ab_edge) m_busy = 0;
                end else if (r >= 2 && r <= DLY + 1 && !inhibit_n) begin
                    ab_edge = e_cnt;
                    m_sticky = 1;
                end else if (r > DLY + WID + 1) begin
                    m_busy = 0;
                end
            end
            if (!was && !sel_n && bus_wr) begin
                m_busy = 1; t0 = e_cnt; ab_edge = -1;
                m_addr = bus_addr; m_data = bus_wdata;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at t=%0t: actual=%0h expected=%0h", req, what, $time, act, exp);
        end
    endtask

    // port-level monitors
    int we_low_cnt = 0;
    int cap_cnt = 0;
    int ack_cnt = 0;
    int cap_edge = 0;
    int last_lat = -1;
    logic prev_we = 1'b1;

    always @(negedge clk) begin
        bit ec, ew, ea;
        int r;
        ec = 1; ew = 1; ea = 0;
        if (m_busy) begin
            r = e_cnt - t0;
            if (ab_edge >= 0) begin
                ea = (e_cnt == ab_edge);
            end else begin
                ec = !(r == 0);
                ew = !(r >= DLY + 1 && r <= DLY + WID);
                ea = (r == DLY + WID + 1);
            end
        end
        if (!rst_n) begin
            check("R11", "cap_n", 64'(cap_n), 64'(1));
            check("R11", "mem_we_n", 64'(mem_we_n), 64'(1));
            check("R11", "ack", 64'(ack), 64'(0));
            check("R11", "abort_flag", 64'(abort_flag), 64'(0));
            check("R11", "mem_addr", 64'(mem_addr), 64'(0));
        end else begin
            check("R1,R2", "cap_n", 64'(cap_n), 64'(ec));
            check("R3,R4,R6,R8", "mem_we_n", 64'(mem_we_n), 64'(ew));
            check("R5,R6", "ack", 64'(ack), 64'(ea));
            check("R7", "abort_flag", 64'(abort_flag), 64'(m_sticky));
            check("R10", "mem_addr", 64'(mem_addr), 64'(m_addr));
            check("R10", "mem_wdata", 64'(mem_wdata), 64'(m_data));
        end
        if (!cap_n) begin cap_cnt++; cap_edge = e_cnt; end
        if (!mem_we_n) we_low_cnt++;
        if (ack) ack_cnt++;
        if (prev_we && !mem_we_n) last_lat = e_cnt - cap_edge;
        prev_we = mem_we_n;
    end

    task automatic step(input logic s_n, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic inh_n);
        @(negedge clk); #1;
        sel_n = s_n; bus_wr = wr; bus_addr = a; bus_wdata = d; inhibit_n = inh_n;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, '0, 1'b1);
    endtask

    initial begin
        int we0, cap0, ack0;
        idle(3);
        @(negedge clk); #1; rst_n = 1'b1;
        idle(2);

        // R2 R3 R4 R5: plain guarded write
        we0 = we_low_cnt; cap0 = cap_cnt;
        step(1'b0, 1'b1, 12'h3A5, 16'hBEEF, 1'b1);
        idle(12);
        check("R3", "strobe latency", 64'(last_lat), 64'(DLY + 1));
        check("R4", "strobe width", 64'(we_low_cnt - we0), 64'(WID));
        check("R2", "capture pulses", 64'(cap_cnt - cap0), 64'(1));

        // R1: select with read, and write without select
        cap0 = cap_cnt;
        step(1'b0, 1'b0, 12'h111, 16'h1111, 1'b1);
        step(1'b1, 1'b1, 12'h222, 16'h2222, 1'b1);
        idle(4);
        check("R1", "no start", 64'(cap_cnt - cap0), 64'(0));

        // R6 R7: inhibit at each guard edge
        for (int k = 0; k < DLY; k++) begin
            we0 = we_low_cnt; ack0 = ack_cnt;
            step(1'b0, 1'b1, AW'(12'h500 + k), DW'(16'hA000 + k), 1'b1);
            idle(1 + k);
            step(1'b1, 1'b0, '0, '0, 1'b0);
            idle(10);
            check("R6", "aborted strobe count", 64'(we_low_cnt - we0), 64'(0));
            check("R6", "abort ack count", 64'(ack_cnt - ack0), 64'(1));
            check("R7", "flag set", 64'(abort_flag), 64'(1));
        end

        // R8: inhibit at capture edge and during strobe is ignored; R7 stays set
        we0 = we_low_cnt;
        step(1'b0, 1'b1, 12'h7C1, 16'h5A5A, 1'b1);
        step(1'b1, 1'b0, '0, '0, 1'b0);
        idle(DLY);
        step(1'b1, 1'b0, '0, '0, 1'b0);
        idle(8);
        check("R8", "strobe despite outer inhibit", 64'(we_low_cnt - we0), 64'(WID));
        check("R7", "flag still set", 64'(abort_flag), 64'(1));

        // R9: select held low for 16 cycles -> two transactions
        cap0 = cap_cnt;
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, AW'(12'h100 + i), DW'(16'h4000 + i), 1'b1);
        idle(12);
        check("R9", "held select transactions", 64'(cap_cnt - cap0), 64'(2));

        // R11: reset in the guard window cancels the strobe and clears the flag
        we0 = we_low_cnt;
        step(1'b0, 1'b1, 12'hFED, 16'hC0DE, 1'b1);
        idle(2);
        @(negedge clk); #1; rst_n = 1'b0;
        idle(3);
        @(negedge clk); #1; rst_n = 1'b1;
        idle(8);
        check("R11", "no strobe after reset", 64'(we_low_cnt - we0), 64'(0));
        check("R11", "flag cleared", 64'(abort_flag), 64'(0));

        // R10: fresh write after reset updates the holding registers
        step(1'b0, 1'b1, 12'h0F0, 16'h1234, 1'b1);
        idle(10);
        check("R10", "captured addr", 64'(mem_addr), 64'(12'h0F0));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule